// File: doc/BRIEF.md
# Object Address Hash Unit

This unit maps an object reference and a linear byte index within that object to a physical address in a banked line memory. It scrambles the line part of the index so that neighbouring lines, and lines of different objects, land on uncorrelated banks. The memory controller can then use the lowest bits of the scrambled line directly as the bank number.

The scrambled line is the XOR of several terms: the line number, its bit-reversed copy, three shifted copies of it, the folded object reference, one word from a sixteen-entry table of random words, and a retry term. A requester that hits a collision asks again with a higher retry count and receives a different placement. The table word is picked by the low four bits of the line number. The table comes out of reset with fixed non-zero words and can be rewritten through its own write port. The unit has a fixed two-cycle pipeline with no back-pressure.

Top module: `obj_hash_unit`

## Requirements
- R1: Bits [4:0] of `rsp_paddr` equal bits [4:0] of the request's `req_index`, unchanged.
- R2: With line L = `req_index[31:5]` (27 bits) and all terms cut to 27 bits, H = L ^ bitreverse(L) ^ (L<<3) ^ (L<<9) ^ (L>>6) ^ fold(`req_ref`) ^ fold(W) ^ (`req_retry` * 0x2545F491). fold(x) XORs bit i of a 32-bit word into bit i mod 27. W is the table word at index L[3:0]. `rsp_paddr[24:5]` is H[19:0] ^ H[26:20].
- R3: `rsp_bank` equals `rsp_paddr[7:5]`, which is the low 3 bits of the physical line.
- R4: `rsp_valid` is high in exactly the cycle two clock edges after a cycle with `req_valid` high, and low otherwise.
- R5: The retry count enters only through the term (`req_retry` * 0x2545F491) mod 2^27. Requests that are the same except for the count produce results that differ by exactly the fold of that term.
- R6: After reset, table entry i holds ((i+1) * 0x9E3779B9) mod 2^32.
- R7: When `tbl_we` is high at a clock edge, entry `tbl_addr` takes `tbl_data`. Requests captured at later edges use the new word. A request captured at the same edge uses the old word.
- R8: While reset is asserted and until the first request has passed through, `rsp_valid` is low. Reset clears `rsp_paddr` and `rsp_bank` to zero.
- R9: Each bit i of `req_ref` flips bit (i mod 27) of H, and has no other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_ref | input | 32 | Object reference |
| req_index | input | 32 | Linear byte index within the object |
| req_retry | input | 4 | Retry count after a collision |
| tbl_we | input | 1 | Random table write enable |
| tbl_addr | input | 4 | Random table entry to write |
| tbl_data | input | 32 | Word to write into the table |
| rsp_valid | output | 1 | Result present this cycle |
| rsp_paddr | output | 25 | Physical address: scrambled line, then byte offset |
| rsp_bank | output | 3 | Bank select |

## Verification
Every result comes out two clock edges after its request. The request and its table word are captured at the first edge, and the mixed address is registered at the second. The bench drives each request at a falling edge and keeps the expected value in a two-deep queue. It compares outputs at the falling edge two steps later, so sampling is always half a cycle away from the registers. The bench keeps its own copy of the table and changes it only after it has computed the expectation for the same cycle. This reproduces the rule that a write becomes visible one edge later.

// File: rtl/obj_hash_pkg.sv
package obj_hash_pkg;
  localparam int unsigned DEF_REF_W   = 32;
  localparam int unsigned DEF_IDX_W   = 32;
  localparam int unsigned DEF_OFS_W   = 5;
  localparam int unsigned DEF_PLINE_W = 20;
  localparam int unsigned DEF_BANK_W  = 3;
  localparam int unsigned DEF_RETRY_W = 4;
  localparam int unsigned DEF_TBL_AW  = 4;
  localparam int unsigned DEF_WORD_W  = 32;
  localparam int unsigned SHL_A       = 3;
  localparam int unsigned SHL_B       = 9;
  localparam int unsigned SHR_A       = 6;
  localparam logic [31:0] RETRY_ODD_K = 32'h2545_F491;
  localparam logic [31:0] TBL_SEED_K  = 32'h9E37_79B9;
endpackage

// File: rtl/hash_word_table.sv
module hash_word_table #(
  parameter int unsigned AW     = 4,
  parameter int unsigned WORD_W = 32,
  parameter logic [31:0] SEED   = 32'h9E37_79B9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [WORD_W-1:0] entry [DEPTH];

  function automatic logic [WORD_W-1:0] seed_word(input int unsigned slot);
    logic [31:0] prod;
    prod = 32'(slot + 1) * SEED;
    return WORD_W'(prod);
  endfunction

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        entry[e] <= seed_word(e);
      else if (wr_en && (wr_addr == AW'(e)))
        entry[e] <= wr_data;
    end
  end

  assign rd_data = entry[rd_addr];
endmodule

// File: rtl/hash_capture_stage.sv
module hash_capture_stage #(
  parameter int unsigned REF_W   = 32,
  parameter int unsigned LINE_W  = 27,
  parameter int unsigned OFS_W   = 5,
  parameter int unsigned RETRY_W = 4,
  parameter int unsigned WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [REF_W-1:0]   in_ref,
  input  logic [LINE_W-1:0]  in_line,
  input  logic [OFS_W-1:0]   in_ofs,
  input  logic [RETRY_W-1:0] in_retry,
  input  logic [WORD_W-1:0]  in_word,
  output logic               q_valid,
  output logic [REF_W-1:0]   q_ref,
  output logic [LINE_W-1:0]  q_line,
  output logic [OFS_W-1:0]   q_ofs,
  output logic [RETRY_W-1:0] q_retry,
  output logic [WORD_W-1:0]  q_word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q_ref   <= '0;
      q_line  <= '0;
      q_ofs   <= '0;
      q_retry <= '0;
      q_word  <= '0;
    end else begin
      q_valid <= in_valid;
      q_ref   <= in_ref;
      q_line  <= in_line;
      q_ofs   <= in_ofs;
      q_retry <= in_retry;
      q_word  <= in_word;
    end
  end
endmodule

// File: rtl/hash_mix_stage.sv
module hash_mix_stage
  import obj_hash_pkg::*;
#(
  parameter int unsigned REF_W   = 32,
  parameter int unsigned LINE_W  = 27,
  parameter int unsigned OFS_W   = 5,
  parameter int unsigned RETRY_W = 4,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned PLINE_W = 20,
  parameter int unsigned BANK_W  = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     s_valid,
  input  logic [REF_W-1:0]         s_ref,
  input  logic [LINE_W-1:0]        s_line,
  input  logic [OFS_W-1:0]         s_ofs,
  input  logic [RETRY_W-1:0]       s_retry,
  input  logic [WORD_W-1:0]        s_word,
  output logic                     o_valid,
  output logic [PLINE_W+OFS_W-1:0] o_paddr,
  output logic [BANK_W-1:0]        o_bank
);
  function automatic logic [LINE_W-1:0] rev_line(input logic [LINE_W-1:0] v);
    logic [LINE_W-1:0] r;
    for (int i = 0; i < LINE_W; i++) r[LINE_W-1-i] = v[i];
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] fold_ref(input logic [REF_W-1:0] v);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = 0; i < REF_W; i++) r[i % LINE_W] ^= v[i];
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] fold_word(input logic [WORD_W-1:0] v);
    logic [LINE_W-1:0] r;
    r = '0;
    for (int i = 0; i < WORD_W; i++) r[i % LINE_W] ^= v[i];
    return r;
  endfunction

  function automatic logic [LINE_W-1:0] retry_mix(input logic [RETRY_W-1:0] c);
    logic [LINE_W-1:0] k;
    k = LINE_W'(RETRY_ODD_K);
    return LINE_W'(LINE_W'(c) * k);
  endfunction

  function automatic logic [PLINE_W-1:0] fold_pline(input logic [LINE_W-1:0] h);
    logic [PLINE_W-1:0] p;
    p = '0;
    for (int i = 0; i < LINE_W; i++) p[i % PLINE_W] ^= h[i];
    return p;
  endfunction

  function automatic logic [LINE_W-1:0] line_hash(
    input logic [LINE_W-1:0]  ln,
    input logic [REF_W-1:0]   rf,
    input logic [WORD_W-1:0]  wd,
    input logic [RETRY_W-1:0] rt
  );
    logic [LINE_W-1:0] sa, sb, sc;
    sa = ln << SHL_A;
    sb = ln << SHL_B;
    sc = ln >> SHR_A;
    return ln ^ rev_line(ln) ^ sa ^ sb ^ sc ^ fold_ref(rf) ^ fold_word(wd) ^ retry_mix(rt);
  endfunction

  logic [PLINE_W-1:0] pline_next;
  assign pline_next = fold_pline(line_hash(s_line, s_ref, s_word, s_retry));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      o_paddr <= '0;
      o_bank  <= '0;
    end else begin
      o_valid <= s_valid;
      o_paddr <= {pline_next, s_ofs};
      o_bank  <= pline_next[BANK_W-1:0];
    end
  end
endmodule

// File: rtl/obj_hash_unit.sv
module obj_hash_unit
  import obj_hash_pkg::*;
#(
  parameter int unsigned REF_W   = DEF_REF_W,
  parameter int unsigned IDX_W   = DEF_IDX_W,
  parameter int unsigned OFS_W   = DEF_OFS_W,
  parameter int unsigned PLINE_W = DEF_PLINE_W,
  parameter int unsigned BANK_W  = DEF_BANK_W,
  parameter int unsigned RETRY_W = DEF_RETRY_W,
  parameter int unsigned TBL_AW  = DEF_TBL_AW,
  parameter int unsigned WORD_W  = DEF_WORD_W,
  localparam int unsigned LINE_W  = IDX_W - OFS_W,
  localparam int unsigned PADDR_W = PLINE_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [REF_W-1:0]   req_ref,
  input  logic [IDX_W-1:0]   req_index,
  input  logic [RETRY_W-1:0] req_retry,
  input  logic               tbl_we,
  input  logic [TBL_AW-1:0]  tbl_addr,
  input  logic [WORD_W-1:0]  tbl_data,
  output logic               rsp_valid,
  output logic [PADDR_W-1:0] rsp_paddr,
  output logic [BANK_W-1:0]  rsp_bank
);
  logic [LINE_W-1:0]  req_line;
  logic [OFS_W-1:0]   req_ofs;
  logic [WORD_W-1:0]  tbl_word;

  logic               s1_valid;
  logic [REF_W-1:0]   s1_ref;
  logic [LINE_W-1:0]  s1_line;
  logic [OFS_W-1:0]   s1_ofs;
  logic [RETRY_W-1:0] s1_retry;
  logic [WORD_W-1:0]  s1_word;

  assign req_line = req_index[IDX_W-1:OFS_W];
  assign req_ofs  = req_index[OFS_W-1:0];

  hash_word_table #(
    .AW(TBL_AW), .WORD_W(WORD_W), .SEED(TBL_SEED_K)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_addr(tbl_addr), .wr_data(tbl_data),
    .rd_addr(req_line[TBL_AW-1:0]), .rd_data(tbl_word)
  );

  hash_capture_stage #(
    .REF_W(REF_W), .LINE_W(LINE_W), .OFS_W(OFS_W),
    .RETRY_W(RETRY_W), .WORD_W(WORD_W)
  ) u_capture (
    .clk(clk), .rst_n(rst_n),
    .in_valid(req_valid), .in_ref(req_ref), .in_line(req_line),
    .in_ofs(req_ofs), .in_retry(req_retry), .in_word(tbl_word),
    .q_valid(s1_valid), .q_ref(s1_ref), .q_line(s1_line),
    .q_ofs(s1_ofs), .q_retry(s1_retry), .q_word(s1_word)
  );

  hash_mix_stage #(
    .REF_W(REF_W), .LINE_W(LINE_W), .OFS_W(OFS_W), .RETRY_W(RETRY_W),
    .WORD_W(WORD_W), .PLINE_W(PLINE_W), .BANK_W(BANK_W)
  ) u_mix (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s1_valid), .s_ref(s1_ref), .s_line(s1_line),
    .s_ofs(s1_ofs), .s_retry(s1_retry), .s_word(s1_word),
    .o_valid(rsp_valid), .o_paddr(rsp_paddr), .o_bank(rsp_bank)
  );
endmodule

// File: rtl/obj_hash_checker.sv
module obj_hash_checker #(
  parameter int unsigned IDX_W  = 32,
  parameter int unsigned OFS_W  = 5,
  parameter int unsigned BANK_W = 3,
  parameter int unsigned PADDR_W = 25
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic [IDX_W-1:0]   req_index,
  input logic               s1_valid,
  input logic               rsp_valid,
  input logic [PADDR_W-1:0] rsp_paddr,
  input logic [BANK_W-1:0]  rsp_bank
);
  logic [1:0] since_rst;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= 2'd0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end
  assign warm = (since_rst == 2'd2);

  // R4
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    warm |-> (rsp_valid == $past(req_valid, 2)));

  // R4
  stage_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> rsp_valid);

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && rsp_valid) |-> (rsp_paddr[OFS_W-1:0] == $past(req_index[OFS_W-1:0], 2)));

  // R3
  bank_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_bank == rsp_paddr[OFS_W +: BANK_W]));

  // R8
  quiet_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !warm |-> !rsp_valid);
endmodule

bind obj_hash_unit obj_hash_checker #(
  .IDX_W(IDX_W), .OFS_W(OFS_W), .BANK_W(BANK_W), .PADDR_W(PADDR_W)
) u_obj_hash_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_index(req_index),
  .s1_valid(s1_valid), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_bank(rsp_bank)
);

// File: tb/tb_obj_hash_unit.sv
module tb_obj_hash_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_ref = '0;
  logic [31:0] req_index = '0;
  logic [3:0]  req_retry = '0;
  logic        tbl_we = 1'b0;
  logic [3:0]  tbl_addr = '0;
  logic [31:0] tbl_data = '0;
  logic        rsp_valid;
  logic [24:0] rsp_paddr;
  logic [2:0]  rsp_bank;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] model_tbl [16];
  bit          e1_v, e2_v;
  logic [24:0] e1_a, e2_a;
  string       e1_tag, e2_tag;

  always #10 clk = ~clk;

  obj_hash_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ref(req_ref),
    .req_index(req_index), .req_retry(req_retry), .tbl_we(tbl_we),
    .tbl_addr(tbl_addr), .tbl_data(tbl_data), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_bank(rsp_bank)
  );

  function automatic logic [26:0] t_fold32(input logic [31:0] w);
    logic [26:0] lo;
    logic [4:0]  hi;
    lo = w[26:0];
    hi = w[31:27];
    return lo ^ {22'd0, hi};
  endfunction

  function automatic logic [24:0] t_expect(input logic [31:0] rf, input logic [31:0] idx,
                                           input logic [3:0] rt, input logic [31:0] wd);
    logic [26:0] ln, rv, h, rmul;
    logic [31:0] prod;
    logic [19:0] pl;
    ln = idx[31:5];
    rv = '0;
    for (int i = 0; i < 27; i++) rv[i] = ln[26-i];
    prod = {28'd0, rt} * 32'h2545_F491;
    rmul = prod[26:0];
    h = ln ^ rv ^ (ln << 3) ^ (ln << 9) ^ (ln >> 6) ^ t_fold32(rf) ^ t_fold32(wd) ^ rmul;
    pl = h[19:0] ^ {13'd0, h[26:20]};
    return {pl, idx[4:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [31:0] rf, input logic [31:0] idx,
                      input logic [3:0] rt, input bit we, input logic [3:0] wa,
                      input logic [31:0] wd, input string tag);
    @(negedge clk);
    // R4 validity two edges after the request
    check(rsp_valid == e2_v, "R4", "valid", {31'd0, rsp_valid}, {31'd0, e2_v});
    if (e2_v) begin
      check(rsp_paddr == e2_a, e2_tag, "paddr", {7'd0, rsp_paddr}, {7'd0, e2_a});
      check(rsp_paddr[4:0] == e2_a[4:0], "R1", "offset", {27'd0, rsp_paddr[4:0]}, {27'd0, e2_a[4:0]});
      check(rsp_bank == e2_a[7:5], "R3", "bank", {29'd0, rsp_bank}, {29'd0, e2_a[7:5]});
    end
    e2_v = e1_v; e2_a = e1_a; e2_tag = e1_tag;
    req_valid = v; req_ref = rf; req_index = idx; req_retry = rt;
    tbl_we = we; tbl_addr = wa; tbl_data = wd;
    e1_v = v;
    e1_a = t_expect(rf, idx, rt, model_tbl[idx[8:5]]);
    e1_tag = tag;
    if (we) model_tbl[wa] = wd;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(1'b0, '0, '0, '0, 1'b0, '0, '0, "R4");
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] base_ref, base_idx;
    void'($urandom(32'd1234));
    // R6 reset contents of the bench's own table copy
    for (int i = 0; i < 16; i++) model_tbl[i] = 32'(i + 1) * 32'h9E37_79B9;
    e1_v = 0; e2_v = 0; e1_a = '0; e2_a = '0; e1_tag = "R2"; e2_tag = "R2";
    repeat (3) @(negedge clk);
    // R8 outputs during reset
    check(rsp_valid == 1'b0, "R8", "valid in reset", {31'd0, rsp_valid}, 32'd0);
    check(rsp_paddr == '0, "R8", "paddr in reset", {7'd0, rsp_paddr}, 32'd0);
    check(rsp_bank == '0, "R8", "bank in reset", {29'd0, rsp_bank}, 32'd0);
    rst_n = 1'b1;
    idle(2);

    // R6 every reset table entry seen through a request
    for (int i = 0; i < 16; i++)
      step(1'b1, 32'd0, {23'd0, 4'(i), 5'(i)}, 4'd0, 1'b0, '0, '0, "R6");
    idle(1);

    // R5 retry sweep on one address
    base_ref = 32'hC0DE_1234; base_idx = 32'h0012_3457;
    for (int r = 0; r < 16; r++)
      step(1'b1, base_ref, base_idx, 4'(r), 1'b0, '0, '0, "R5");

    // R9 single-bit references
    for (int b = 0; b < 32; b++)
      step(1'b1, 32'd1 << b, 32'h0000_0A60, 4'd0, 1'b0, '0, '0, "R9");

    // R7 write and same-cycle request sees old word, next sees new
    step(1'b1, 32'h5, 32'h0000_00E3, 4'd2, 1'b1, 4'd7, 32'hDEAD_BEEF, "R7");
    step(1'b1, 32'h5, 32'h0000_00E3, 4'd2, 1'b0, '0, '0, "R7");
    step(1'b1, 32'h5, 32'h0000_00E3, 4'd2, 1'b1, 4'd3, 32'h0, "R7");
    step(1'b1, 32'h9, 32'h0000_0060, 4'd0, 1'b0, '0, '0, "R7");

    // R2 corner indexes
    step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'hF, 1'b0, '0, '0, "R2");
    step(1'b1, 32'h0, 32'h0, 4'h0, 1'b0, '0, '0, "R2");
    step(1'b1, 32'h8000_0000, 32'h8000_001F, 4'h1, 1'b0, '0, '0, "R1");
    idle(3);

    // R2 constrained random traffic with table writes and gaps
    for (int n = 0; n < 3000; n++) begin
      bit v, we;
      v  = ($urandom % 4) != 0;
      we = ($urandom % 8) == 0;
      step(v, $urandom, $urandom, 4'($urandom), we, 4'($urandom), $urandom, "R2");
    end
    idle(3);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule